// File: doc/BRIEF.md
# Stepwise Two-Wire Bus Master

This block is the master half of a two-wire serial bus controller that moves one bus step at a time. Software writes a command into a control register. The engine then generates a START, a repeated START, one byte phase (address, transmit or receive) or a STOP on open-drain clock and data lines. When the step is done it raises an event flag and publishes an 8-bit status code that says what happened. The engine then holds the clock low until software writes the next command. It never runs a whole transfer by itself.

A transfer runs as follows. Software requests START, loads the address byte into the data register and clears the event flag to send it. It then moves data bytes one by one. In receive mode, an acknowledge-enable bit in the command picks ACK or NAK for each received byte. A STOP returns the engine to idle. An interrupt output follows the status code when it is enabled through a separate interrupt register.

Top module: `twm_master`

## Requirements
- R1: After reset both line drive-low enables are 0, status is 0xF8, the event flag is 0 and the interrupt output is 0.
- R2: With enable (control bit 0x40) set, a control write with START (bit 0x20) while idle and both lines high pulls SDA low while SCL is released, then pulls SCL low. It ends with status 0x08 and the event flag set.
- R3: A START request while idle and SDA (or SCL) is sampled low issues nothing. Both lines stay released, status stays 0xF8 and the event flag stays 0.
- R4: A control write with enable set, no START or STOP, and the event-flag bit 0x08 clear, made after status 0x08 or 0x10, sends the data register MSB first as the address byte (target << 1 | read bit). The status becomes 0x18 or 0x20 for a write (ACK or NAK) and 0x40 or 0x48 for a read (ACK or NAK).
- R5: The same command in transmit mode sends the data register MSB first. The status becomes 0x28 when the target ACKs and 0x30 when it NAKs.
- R6: In receive mode the same command clocks in a byte MSB first into the data register. With acknowledge bit 0x04 set, the master drives SDA low in the ninth clock and the status becomes 0x50. With the bit clear, SDA is left released and the status becomes 0x58.
- R7: A START request while the engine holds the bus after an event produces a repeated START and status 0x10.
- R8: A STOP request (bit 0x10) while holding the bus raises SDA while SCL is released. Afterwards both lines are released, status is 0xF8 and the event flag is 0.
- R9: While holding the bus, a control write with enable set and the event-flag bit 0x08 set starts nothing. The event flag, status and lines stay unchanged.
- R10: Bit 6 (0x40) of the interrupt register (select 2) enables the interrupt. The interrupt output is high exactly when it is enabled and the status is not 0xF8.
- R11: The lines are driven only low, through drive-low enables. SDA changes while SCL is released only during START, repeated START and STOP.
- R12: When the engine releases SCL and the line stays low, the engine waits before sampling and continues once SCL is high.
- R13: Control writes with enable (0x40) clear start no bus activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 data, 2 interrupt enable |
| reg_wdata | input | 8 | Register write value |
| stat_o | output | 8 | Status code |
| data_o | output | 8 | Data register (received byte after a read phase) |
| evt_o | output | 1 | Event flag: a bus step finished |
| irq_o | output | 1 | Interrupt request |
| scl_i | input | 1 | Sampled SCL line |
| sda_i | input | 1 | Sampled SDA line |
| scl_oe_o | output | 1 | Drive SCL low when 1 |
| sda_oe_o | output | 1 | Drive SDA low when 1 |

## Verification
The assertions watch, on every cycle, the relations that hold between one state of the engine and the next. These cover the refused START under a low SDA, the end state after STOP and after START, a command that keeps the event flag set and starts nothing, the stall while SCL is held low, and SDA staying put while SCL is released outside framing steps. Whether the right bits reach the bus, whether the status codes follow the ACK that a target gives, and how repeated START and receive-side NAK fit into a whole transfer can only be shown by the bench. The bench does this with a small target model on the wires that acknowledges, refuses, supplies bytes and stretches the clock.

// File: rtl/twm_pkg.sv
package twm_pkg;
    localparam int BYTE_W = 8;
    localparam int BCNT_W = $clog2(BYTE_W + 1);

    // control register bit positions
    localparam int CB_ENAB = 6;
    localparam int CB_STA  = 5;
    localparam int CB_STP  = 4;
    localparam int CB_IFLG = 3;
    localparam int CB_AAK  = 2;
    // interrupt register enable bit
    localparam int IB_EN   = 6;

    localparam logic [7:0] ST_START   = 8'h08;
    localparam logic [7:0] ST_RSTART  = 8'h10;
    localparam logic [7:0] ST_AW_ACK  = 8'h18;
    localparam logic [7:0] ST_AW_NAK  = 8'h20;
    localparam logic [7:0] ST_DW_ACK  = 8'h28;
    localparam logic [7:0] ST_DW_NAK  = 8'h30;
    localparam logic [7:0] ST_AR_ACK  = 8'h40;
    localparam logic [7:0] ST_AR_NAK  = 8'h48;
    localparam logic [7:0] ST_DR_ACK  = 8'h50;
    localparam logic [7:0] ST_DR_NAK  = 8'h58;
    localparam logic [7:0] ST_IDLE    = 8'hF8;

    typedef enum logic [2:0] {
        S_IDLE, S_START, S_RESTART, S_BYTE, S_STOP, S_WAIT
    } eng_st_e;

    typedef struct packed {
        eng_st_e             st;
        logic [1:0]          q;
        logic [BCNT_W-1:0]   bitn;
        logic [BYTE_W-1:0]   shf;
        logic [BYTE_W-1:0]   data;
        logic [7:0]          stat;
        logic                evt;
        logic                rx;
        logic                addr_ph;
        logic                aak;
        logic                ack;
        logic                scl_oe;
        logic                sda_oe;
    } eng_s;
endpackage

// File: rtl/twm_tick.sv
module twm_tick #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);
    generate
        if (DIV <= 1) begin : g_direct
            assign tick_o = run_i;
        end else begin : g_count
            localparam int CW = $clog2(DIV);
            logic [CW-1:0] cnt_d, cnt_q;

            always_comb begin
                cnt_d = cnt_q;
                if (!run_i)
                    cnt_d = '0;
                else if (cnt_q == CW'(DIV - 1))
                    cnt_d = '0;
                else
                    cnt_d = cnt_q + 1'b1;
            end

            always_ff @(posedge clk) begin
                if (!rst_n) cnt_q <= '0;
                else        cnt_q <= cnt_d;
            end

            assign tick_o = run_i && (cnt_q == CW'(DIV - 1));
        end
    endgenerate
endmodule

// File: rtl/twm_engine.sv
module twm_engine
    import twm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              wr_ctrl_i,
    input  logic              wr_data_i,
    input  logic [7:0]        wdata_i,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              busy_o,
    output logic [7:0]        stat_o,
    output logic [BYTE_W-1:0] data_o,
    output logic              evt_o,
    output logic              scl_oe_o,
    output logic              sda_oe_o
);
    localparam logic [BCNT_W-1:0] ACK_BIT = BCNT_W'(BYTE_W);

    eng_s r_q, r_d;
    logic busy, adv, tx;

    assign busy = (r_q.st != S_IDLE) && (r_q.st != S_WAIT);
    assign tx   = r_q.addr_ph || !r_q.rx;

    always_comb begin
        r_d = r_q;
        adv = 1'b1;
        if (wr_data_i && !busy) r_d.data = wdata_i;
        if (wr_ctrl_i && !busy) begin
            r_d.aak = wdata_i[CB_AAK];
            if (wdata_i[CB_ENAB]) begin
                if (wdata_i[CB_STA]) begin
                    if (r_q.st == S_IDLE) begin
                        if (sda_i && scl_i) begin
                            r_d.st = S_START;
                            r_d.q  = '0;
                        end
                    end else begin
                        r_d.st  = S_RESTART;
                        r_d.q   = '0;
                        r_d.evt = 1'b0;
                    end
                end else if (wdata_i[CB_STP]) begin
                    if (r_q.st == S_WAIT) begin
                        r_d.st  = S_STOP;
                        r_d.q   = '0;
                        r_d.evt = 1'b0;
                    end
                end else if (r_q.st == S_WAIT && !wdata_i[CB_IFLG]) begin
                    r_d.st      = S_BYTE;
                    r_d.q       = '0;
                    r_d.bitn    = '0;
                    r_d.evt     = 1'b0;
                    r_d.shf     = r_q.data;
                    r_d.addr_ph = (r_q.stat == ST_START) || (r_q.stat == ST_RSTART);
                end
            end
        end
        if (tick_i && busy) begin
            unique case (r_q.st)
                S_START: begin
                    if (r_q.q == 2'd0) r_d.sda_oe = 1'b1;
                    if (r_q.q == 2'd2) r_d.scl_oe = 1'b1;
                    if (r_q.q == 2'd3) begin
                        r_d.st   = S_WAIT;
                        r_d.stat = ST_START;
                        r_d.evt  = 1'b1;
                    end
                end
                S_RESTART: begin
                    case (r_q.q)
                        2'd0: r_d.sda_oe = 1'b0;
                        2'd1: r_d.scl_oe = 1'b0;
                        2'd2: if (scl_i) r_d.sda_oe = 1'b1; else adv = 1'b0;
                        default: begin
                            r_d.scl_oe = 1'b1;
                            r_d.st     = S_WAIT;
                            r_d.stat   = ST_RSTART;
                            r_d.evt    = 1'b1;
                        end
                    endcase
                end
                S_STOP: begin
                    case (r_q.q)
                        2'd0: r_d.sda_oe = 1'b1;
                        2'd1: r_d.scl_oe = 1'b0;
                        2'd2: if (scl_i) r_d.sda_oe = 1'b0; else adv = 1'b0;
                        default: begin
                            r_d.st   = S_IDLE;
                            r_d.stat = ST_IDLE;
                        end
                    endcase
                end
                S_BYTE: begin
                    case (r_q.q)
                        2'd0: begin
                            if (tx)
                                r_d.sda_oe = (r_q.bitn != ACK_BIT) && !r_q.shf[BYTE_W-1];
                            else
                                r_d.sda_oe = (r_q.bitn == ACK_BIT) && r_q.aak;
                        end
                        2'd1: r_d.scl_oe = 1'b0;
                        2'd2: begin
                            if (!scl_i)
                                adv = 1'b0;
                            else if (r_q.bitn != ACK_BIT)
                                r_d.shf = {r_q.shf[BYTE_W-2:0], sda_i};
                            else
                                r_d.ack = !sda_i;
                        end
                        default: begin
                            r_d.scl_oe = 1'b1;
                            if (r_q.bitn != ACK_BIT) begin
                                r_d.bitn = r_q.bitn + 1'b1;
                            end else begin
                                r_d.st  = S_WAIT;
                                r_d.evt = 1'b1;
                                if (r_q.addr_ph) begin
                                    r_d.rx   = r_q.data[0];
                                    r_d.stat = r_q.data[0] ? (r_q.ack ? ST_AR_ACK : ST_AR_NAK)
                                                           : (r_q.ack ? ST_AW_ACK : ST_AW_NAK);
                                end else if (r_q.rx) begin
                                    r_d.data = r_q.shf;
                                    r_d.stat = r_q.ack ? ST_DR_ACK : ST_DR_NAK;
                                end else begin
                                    r_d.stat = r_q.ack ? ST_DW_ACK : ST_DW_NAK;
                                end
                            end
                        end
                    endcase
                end
                default: ;
            endcase
            if (adv) r_d.q = r_q.q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.st   <= S_IDLE;
            r_q.stat <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o   = busy;
    assign stat_o   = r_q.stat;
    assign data_o   = r_q.data;
    assign evt_o    = r_q.evt;
    assign scl_oe_o = r_q.scl_oe;
    assign sda_oe_o = r_q.sda_oe;

    // R2: START step ends with the bus held and the start code posted
    a_r2_start_done: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_START && tick_i && r_q.q == 2'd3)
        |=> (r_q.stat == ST_START && r_q.evt && r_q.scl_oe && r_q.sda_oe));

    // R3: refused START when SDA is low
    a_r3_blocked_start: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_IDLE && wr_ctrl_i && wdata_i[CB_ENAB] && wdata_i[CB_STA] && !sda_i)
        |=> (r_q.st == S_IDLE && r_q.stat == ST_IDLE && !r_q.evt && !r_q.sda_oe));

    // R8: STOP leaves lines released and status idle
    a_r8_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_STOP && tick_i && r_q.q == 2'd3)
        |=> (r_q.st == S_IDLE && r_q.stat == ST_IDLE && !r_q.scl_oe && !r_q.sda_oe && !r_q.evt));

    // R9: command with event-flag bit set starts nothing
    a_r9_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_WAIT && wr_ctrl_i && wdata_i[CB_ENAB] && !wdata_i[CB_STA]
         && !wdata_i[CB_STP] && wdata_i[CB_IFLG])
        |=> (r_q.st == S_WAIT && r_q.evt && $stable(r_q.stat)));

    // R11: SDA moves under a released SCL only in framing steps
    a_r11_sda_framing: assert property (@(posedge clk) disable iff (!rst_n)
        (!r_q.scl_oe && !$stable(r_q.sda_oe))
        |-> (r_q.st == S_START || r_q.st == S_RESTART || r_q.st == S_STOP));

    // R12: stall while SCL is held low by another device
    a_r12_scl_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && tick_i && r_q.q == 2'd2 && !scl_i)
        |=> (r_q.q == 2'd2 && $stable(r_q.st)));
endmodule

// File: rtl/twm_master.sv
module twm_master
    import twm_pkg::*;
#(
    parameter int DIV = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_we,
    input  logic [1:0] reg_sel,
    input  logic [7:0] reg_wdata,
    output logic [7:0] stat_o,
    output logic [7:0] data_o,
    output logic       evt_o,
    output logic       irq_o,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       scl_oe_o,
    output logic       sda_oe_o
);
    localparam logic [1:0] SEL_CTRL = 2'd0;
    localparam logic [1:0] SEL_DATA = 2'd1;
    localparam logic [1:0] SEL_INT  = 2'd2;

    logic int_en_d, int_en_q;
    logic busy, tick;
    logic [7:0] stat;

    always_comb begin
        int_en_d = int_en_q;
        if (reg_we && reg_sel == SEL_INT) int_en_d = reg_wdata[IB_EN];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) int_en_q <= 1'b0;
        else        int_en_q <= int_en_d;
    end

    twm_tick #(.DIV(DIV)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (busy),
        .tick_o (tick)
    );

    twm_engine u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick),
        .wr_ctrl_i (reg_we && reg_sel == SEL_CTRL),
        .wr_data_i (reg_we && reg_sel == SEL_DATA),
        .wdata_i   (reg_wdata),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .busy_o    (busy),
        .stat_o    (stat),
        .data_o    (data_o),
        .evt_o     (evt_o),
        .scl_oe_o  (scl_oe_o),
        .sda_oe_o  (sda_oe_o)
    );

    assign stat_o = stat;
    assign irq_o  = int_en_q && (stat != ST_IDLE);
endmodule

// File: tb/twm_master_tb.sv
module twm_master_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_we = 1'b0;
    logic [1:0] reg_sel = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] stat, data;
    logic evt, irq, scl_oe, sda_oe;

    // target model
    logic rxmode = 1'b0, slv_ack = 1'b1, hold_scl = 1'b0, hold_sda = 1'b0;
    logic [7:0] slv_byte = '0, cap = '0;
    logic mack = 1'b0;
    int falls = 0, base = 0, starts = 0, stops = 0;
    int n_chk = 0, n_fail = 0;
    int bitn;
    logic slv_drive, scl_w, sda_w;

    always #2 clk = ~clk;

    assign bitn      = falls - base;
    assign slv_drive = rxmode ? (bitn >= 0 && bitn < 8 && !slv_byte[3'(7 - bitn)])
                              : (bitn == 8 && slv_ack);
    assign scl_w = !(scl_oe || hold_scl);
    assign sda_w = !(sda_oe || slv_drive || hold_sda);

    always @(negedge scl_w) falls++;
    always @(posedge scl_w) begin
        if (bitn >= 0 && bitn < 8) cap = {cap[6:0], sda_w};
        else if (bitn == 8) mack = !sda_w;
    end
    always @(negedge sda_w) if (scl_w === 1'b1) starts++;
    always @(posedge sda_w) if (scl_w === 1'b1) stops++;

    twm_master dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .stat_o(stat), .data_o(data), .evt_o(evt),
        .irq_o(irq), .scl_i(scl_w), .sda_i(sda_w),
        .scl_oe_o(scl_oe), .sda_oe_o(sda_oe)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_evt(input string tag);
        int k = 0;
        while (!evt && k < 3000) begin @(negedge clk); k++; end
        chk(evt, {tag, " event"}, evt, 1);
    endtask

    task automatic byte_cmd(input logic [7:0] ctrl, input string tag);
        base = falls;
        wr(2'd0, ctrl);
        wait_evt(tag);
    endtask

    task automatic t_reset;
        chk(stat == 8'hF8, "R1 status", stat, 8'hF8);
        chk(!evt && !irq, "R1 evt/irq", {evt, irq}, 0);
        chk(!scl_oe && !sda_oe, "R1 lines", {scl_oe, sda_oe}, 0);
    endtask

    task automatic t_start(input logic [7:0] expst, input string tag);
        int s0 = starts;
        wr(2'd0, 8'h60);
        wait_evt(tag);
        chk(stat == expst, {tag, " status"}, stat, expst);
        chk(starts == s0 + 1, {tag, " start seen"}, starts - s0, 1);
    endtask

    task automatic t_addr_write;
        slv_ack = 1'b1;
        wr(2'd1, 8'hB4);
        byte_cmd(8'h40, "R4");
        chk(stat == 8'h18, "R4 write addr ack", stat, 8'h18);
        chk(cap == 8'hB4, "R4 address bits", cap, 8'hB4);
    endtask

    task automatic t_flag_hold;
        wr(2'd0, 8'h48);
        idle(120);
        chk(evt && stat == 8'h18, "R9 no action", {evt, stat}, {1'b1, 8'h18});
        chk(scl_oe, "R9 clock held", scl_oe, 1);
    endtask

    task automatic t_tx_data;
        slv_ack = 1'b1;
        wr(2'd1, 8'h3C);
        byte_cmd(8'h40, "R5");
        chk(stat == 8'h28 && cap == 8'h3C, "R5 data ack", {stat, cap}, {8'h28, 8'h3C});
        slv_ack = 1'b0;
        wr(2'd1, 8'hC3);
        byte_cmd(8'h40, "R5");
        chk(stat == 8'h30 && cap == 8'hC3, "R5 data nak", {stat, cap}, {8'h30, 8'hC3});
    endtask

    task automatic t_scl_wait;
        slv_ack = 1'b1;
        wr(2'd1, 8'h81);
        hold_scl = 1'b1;
        base = falls;
        wr(2'd0, 8'h40);
        idle(300);
        chk(!evt && stat == 8'h30, "R12 stalled", {evt, stat}, {1'b0, 8'h30});
        hold_scl = 1'b0;
        wait_evt("R12");
        chk(stat == 8'h28 && cap == 8'h81, "R12 resumed", {stat, cap}, {8'h28, 8'h81});
    endtask

    task automatic t_read;
        slv_ack = 1'b1;
        wr(2'd1, 8'hB5);
        byte_cmd(8'h40, "R4");
        chk(stat == 8'h40, "R4 read addr ack", stat, 8'h40);
        rxmode = 1'b1;
        slv_byte = 8'hA7;
        byte_cmd(8'h44, "R6");
        chk(stat == 8'h50 && data == 8'hA7, "R6 rx ack", {stat, data}, {8'h50, 8'hA7});
        chk(mack, "R6 master ack", mack, 1);
        slv_byte = 8'h19;
        byte_cmd(8'h40, "R6");
        chk(stat == 8'h58 && data == 8'h19, "R6 rx nak", {stat, data}, {8'h58, 8'h19});
        chk(!mack, "R6 master nak", mack, 0);
    endtask

    task automatic t_stop(input string tag);
        int p0 = stops;
        int k = 0;
        wr(2'd0, 8'h50);
        while (stat != 8'hF8 && k < 2000) begin @(negedge clk); k++; end
        rxmode = 1'b0;
        chk(stat == 8'hF8 && !evt, {tag, " idle"}, {stat, evt}, {8'hF8, 1'b0});
        chk(stops == p0 + 1, {tag, " stop seen"}, stops - p0, 1);
        chk(!scl_oe && !sda_oe, {tag, " lines released"}, {scl_oe, sda_oe}, 0);
    endtask

    task automatic t_disabled;
        int s0 = starts;
        wr(2'd0, 8'h20);
        idle(100);
        chk(stat == 8'hF8 && !evt && starts == s0, "R13 no start", stat, 8'hF8);
        chk(!scl_oe && !sda_oe, "R13 lines", {scl_oe, sda_oe}, 0);
    endtask

    task automatic t_blocked;
        hold_sda = 1'b1;
        idle(2);
        wr(2'd0, 8'h60);
        idle(100);
        chk(stat == 8'hF8 && !evt, "R3 refused", {stat, evt}, {8'hF8, 1'b0});
        chk(!scl_oe && !sda_oe, "R3 lines", {scl_oe, sda_oe}, 0);
        hold_sda = 1'b0;
        idle(2);
    endtask

    task automatic t_addr_nak;
        t_start(8'h08, "R2");
        slv_ack = 1'b0;
        wr(2'd1, 8'hB4);
        byte_cmd(8'h40, "R4");
        chk(stat == 8'h20, "R4 write addr nak", stat, 8'h20);
        t_stop("R8");
    endtask

    initial begin
        int cyc = 0;
        while (cyc < 150000) begin @(posedge clk); cyc++; end
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        idle(4);
        rst_n = 1'b1;
        idle(2);
        t_reset();
        wr(2'd2, 8'h40);
        idle(2);
        chk(!irq, "R10 irq low when idle", irq, 0);
        t_start(8'h08, "R2");
        chk(scl_oe && sda_oe, "R2 bus held", {scl_oe, sda_oe}, 3);
        chk(irq, "R10 irq high", irq, 1);
        t_addr_write();
        t_flag_hold();
        t_tx_data();
        t_scl_wait();
        t_start(8'h10, "R7");
        t_read();
        t_stop("R8");
        chk(!irq, "R10 irq after stop", irq, 0);
        t_disabled();
        t_blocked();
        t_addr_nak();
        wr(2'd2, 8'h00);
        t_start(8'h08, "R2");
        chk(!irq, "R10 irq masked", irq, 0);
        t_stop("R8");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule